// File: doc/BRIEF.md
# Serial Transmit Path with Character Buffer

This block turns bytes written by a host into asynchronous serial frames. Each byte is written through a single write port. It waits in a buffer until the shifter is free. The shifter then sends a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The timing comes from a 16x bit-rate enable that a separate rate generator supplies. Every serial bit spans sixteen of those enables.

The buffer works in one of two modes, chosen at run time. In queued mode it holds up to `DEPTH` characters. In single mode it holds one character, like a classic holding register. Two status outputs tell the host what state the path is in. One reports an empty buffer, meaning the host may write again. The other reports that the whole path is drained, meaning the last stop bit has left the line. When the buffer drains into the shifter, the block latches a transmit-empty interrupt request. Its output is gated by an enable, and a write or an interrupt-status read clears it.

Top module: `uart_tx_fifo`

## Requirements
- R1: After reset `txd` is 1, `thr_empty` is 1, `tsr_empty` is 1 and `irq_tx` is 0.
- R2: Every serial bit, including the start bit (level 0), lasts exactly 16 pulses of `tick16`.
- R3: Data bits leave least significant bit first, directly after the start bit.
- R4: `word_len` encodes the data width as 0=5, 1=6, 2=7, 3=8 bits; the higher byte bits are not sent.
- R5: With `parity_en`=1 a parity bit follows the data. With `parity_odd`=1 the data plus parity hold an odd number of ones, otherwise an even number.
- R6: The frame ends with two stop bits (level 1) when `two_stop`=1, otherwise with one.
- R7: With `fifo_mode`=1 up to `DEPTH` bytes wait in the buffer and are sent in write order. A write while the buffer is full is dropped.
- R8: With `fifo_mode`=0 one byte waits. A write while it is occupied is dropped, and `thr_empty` goes to 1 in the cycle after the byte moves into the shifter.
- R9: `tsr_empty` is 1 only when the shifter has sent its last stop bit and no byte is waiting.
- R10: A pending flag sets when the last waiting byte moves into the shifter. `irq_tx` equals that flag ANDed with `ie_tx_empty`.
- R11: A pulse on `wr_en` or on `isr_read` clears the pending flag, and `irq_tx` is 0 in the next cycle.
- R12: `txd` is 1 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | 16x bit-rate enable |
| wr_en | input | 1 | Write strobe for a transmit byte |
| wr_data | input | 8 | Transmit byte |
| fifo_mode | input | 1 | 1 selects queued mode, 0 selects single mode |
| word_len | input | 2 | Data width code (5 to 8 bits) |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| ie_tx_empty | input | 1 | Transmit-empty interrupt enable |
| isr_read | input | 1 | Interrupt status read strobe |
| txd | output | 1 | Serial output |
| thr_empty | output | 1 | No byte waiting |
| tsr_empty | output | 1 | Whole transmit path drained |
| irq_tx | output | 1 | Transmit-empty interrupt request |

## Verification
The bench builds the block with `DEPTH`=4. With that depth the full-buffer case comes within reach after five back-to-back writes. In that case one byte is already in the shifter and the sixth write is dropped, and the bench confirms that only five frames leave the line. The bench drives `tick16` on every second clock, so one bit spans 32 clocks. This makes the start-bit length measurable to the clock, and lets a bench-side receiver sample each bit at its centre across all word widths, parity modes and stop counts.

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_mode,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       two_stop,
  input  logic       ie_tx_empty,
  input  logic       isr_read,
  output logic       txd,
  output logic       thr_empty,
  output logic       tsr_empty,
  output logic       irq_tx
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic [11:0]   sh, frame;
  logic [3:0]    bits_left, tcnt, nbits, wlen;
  logic          busy, pend, par;

  wire [AW:0] cap  = fifo_mode ? (AW+1)'(DEPTH) : (AW+1)'(1);
  wire        push = wr_en && (count < cap);
  wire        pop  = !busy && (count != '0);
  wire [7:0]  head = mem[rptr];

  assign wlen = 4'd5 + {2'b00, word_len};

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    par = parity_odd;
    for (int i = 0; i < 8; i++)
      if (i < int'(wlen)) begin
        frame[i+1] = head[i];
        par = par ^ head[i];
      end
    if (parity_en) frame[int'(wlen)+1] = par;
    nbits = 4'd2 + wlen + {3'b000, parity_en} + {3'b000, two_stop};
  end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      tcnt      <= '0;
    end else if (pop) begin
      busy      <= 1'b1;
      sh        <= frame;
      bits_left <= nbits;
      tcnt      <= '0;
    end else if (busy && tick16) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == 4'd15) begin
        sh        <= {1'b1, sh[11:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == 4'd1) busy <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  pend <= 1'b0;
    else if (wr_en || isr_read)  pend <= 1'b0;
    else if (pop && count == 1)  pend <= 1'b1;

  assign txd       = busy ? sh[0] : 1'b1;
  assign thr_empty = (count == '0);
  assign tsr_empty = !busy && (count == '0);
  assign irq_tx    = pend && ie_tx_empty;
endmodule

// File: rtl/uart_tx_fifo_chk.sv
module uart_tx_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic isr_read,
  input logic ie_tx_empty,
  input logic txd,
  input logic thr_empty,
  input logic tsr_empty,
  input logic irq_tx
);
  // R12
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n) tsr_empty |-> txd);
  // R9
  drained_chk: assert property (@(posedge clk) disable iff (!rst_n) tsr_empty |-> thr_empty);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_tx |-> ie_tx_empty);
  // R11
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !irq_tx);
  // R11
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) isr_read |=> !irq_tx);
  // R7
  fill_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(thr_empty) |-> $past(wr_en));
endmodule

bind uart_tx_fifo uart_tx_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .isr_read(isr_read),
  .ie_tx_empty(ie_tx_empty), .txd(txd), .thr_empty(thr_empty),
  .tsr_empty(tsr_empty), .irq_tx(irq_tx)
);

// File: tb/test_uart_tx_fifo.sv
`timescale 1ns/1ps
module test_uart_tx_fifo;
  logic clk = 0, rst_n = 0, tick16 = 0, wr_en = 0, fifo_mode = 0;
  logic parity_en = 0, parity_odd = 0, two_stop = 0, ie_tx_empty = 0, isr_read = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] word_len = 2'd3;
  logic txd, thr_empty, tsr_empty, irq_tx;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  uart_tx_fifo #(.DEPTH(4)) i_uart_tx_fifo (.*);

  // data, word_len, parity_en, parity_odd, two_stop
  localparam logic [12:0] VEC [6] = '{
    {8'hA5, 2'd3, 1'b1, 1'b0, 1'b0},
    {8'h3C, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'hFF, 2'd1, 1'b1, 1'b1, 1'b1},
    {8'h81, 2'd2, 1'b1, 1'b0, 1'b1},
    {8'h00, 2'd3, 1'b1, 1'b1, 1'b0},
    {8'h6E, 2'd3, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rx(input logic [7:0] d, input string dtag);
    int wl;
    logic p;
    logic prev;
    wl = 5 + int'(word_len);
    prev = txd;
    forever begin
      @(negedge clk);
      if (prev && !txd) break;
      prev = txd;
    end
    repeat (15) @(negedge clk);
    chk(txd == 0, "R2 start", txd, 0);
    p = parity_odd;
    for (int i = 0; i < wl; i++) begin
      repeat (32) @(negedge clk);
      chk(txd == d[i], dtag, txd, d[i]);
      p = p ^ d[i];
    end
    if (parity_en) begin
      repeat (32) @(negedge clk);
      chk(txd == p, "R5 parity", txd, p);
    end
    repeat (32) @(negedge clk);
    chk(txd == 1, "R6 stop1", txd, 1);
    if (two_stop) begin
      repeat (32) @(negedge clk);
      chk(txd == 1, "R6 stop2", txd, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int low;
    repeat (3) @(negedge clk);
    // R1
    chk(txd == 1, "R1 txd", txd, 1);
    chk(thr_empty == 1, "R1 thr_empty", thr_empty, 1);
    chk(tsr_empty == 1, "R1 tsr_empty", tsr_empty, 1);
    chk(irq_tx == 0, "R1 irq", irq_tx, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(txd == 1, "R12 idle", txd, 1);

    // R3 R4 R5 R6 via vector table
    foreach (VEC[k]) begin
      word_len = VEC[k][4:3]; parity_en = VEC[k][2];
      parity_odd = VEC[k][1]; two_stop = VEC[k][0];
      fork
        wr(VEC[k][12:5]);
        rx(VEC[k][12:5], "R3/R4 data");
      join
      repeat (40) @(negedge clk);
      chk(tsr_empty == 1, "R9 drained", tsr_empty, 1);
      chk(txd == 1, "R12 idle", txd, 1);
    end

    // R2 start bit length
    word_len = 2'd3; parity_en = 0; two_stop = 0;
    wr(8'h01);
    while (txd) @(negedge clk);
    low = 0;
    while (!txd) begin low++; @(negedge clk); end
    chk(low == 31 || low == 32, "R2 bit length", low, 32);
    wait (tsr_empty); repeat (4) @(negedge clk);

    // R7 queued mode, full buffer drop
    fifo_mode = 1; ie_tx_empty = 1;
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge clk); wr_en = 1; wr_data = 8'hA1 + 8'(i);
        end
        @(negedge clk); wr_en = 0;
        chk(thr_empty == 0, "R7 holding", thr_empty, 0);
        chk(tsr_empty == 0, "R9 busy", tsr_empty, 0);
      end
      for (int i = 0; i < 5; i++) rx(8'hA1 + 8'(i), "R7 order");
    join
    repeat (40) @(negedge clk);
    chk(tsr_empty == 1, "R7 sixth dropped", tsr_empty, 1);
    chk(irq_tx == 1, "R10 set", irq_tx, 1);
    @(negedge clk); isr_read = 1;
    @(negedge clk); isr_read = 0;
    chk(irq_tx == 0, "R11 read clears", irq_tx, 0);

    // R8 single mode
    fifo_mode = 0;
    fork
      begin
        @(negedge clk); wr_en = 1; wr_data = 8'hB1;
        @(negedge clk); wr_en = 0;
        chk(thr_empty == 0, "R8 held", thr_empty, 0);
        @(negedge clk);
        chk(thr_empty == 1, "R8 moved", thr_empty, 1);
        chk(irq_tx == 1, "R10 set", irq_tx, 1);
        wr(8'hB2);
        chk(irq_tx == 0, "R11 write clears", irq_tx, 0);
        chk(thr_empty == 0, "R8 second held", thr_empty, 0);
        wr(8'hB3);
      end
      begin
        rx(8'hB1, "R8 first");
        rx(8'hB2, "R8 second");
      end
    join
    repeat (40) @(negedge clk);
    chk(tsr_empty == 1, "R8 third dropped", tsr_empty, 1);
    chk(irq_tx == 1, "R10 set", irq_tx, 1);
    ie_tx_empty = 0;
    @(negedge clk);
    chk(irq_tx == 0, "R10 gated", irq_tx, 0);
    ie_tx_empty = 1;
    @(negedge clk);
    chk(irq_tx == 1, "R10 ungated", irq_tx, 1);
    chk(txd == 1, "R12 idle", txd, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule